// File: doc/BRIEF.md
# Arithmetic Syndrome Corrector for Four Parallel Filters

This block sits behind a bank of four identical filters that process four different input streams, plus three redundant check filters. Each check filter is fed the sum of a fixed group of three of the data inputs. Every clock cycle the block takes one output sample from each of the seven filters. For each check it forms a residual: the check sample minus the sum of the three data samples in its group. It then compares the magnitude of that residual with a programmable tolerance, which gives one syndrome bit per check.

The tolerance absorbs the small rounding differences that appear between the data and check arithmetic. A syndrome pattern with two or three bits set points to exactly one data filter. The block rebuilds that filter's sample by subtraction from a check sample and the two other samples in the same group. A pattern with one bit set blames a check filter, and the data is left alone. The four samples, the syndrome and an error flag are registered together, with one cycle of latency.

The three residual paths share no logic. The rebuild-and-select stage is instantiated three times, and a bitwise majority vote combines the three copies.

Top module: `fault_mask_corrector`

## Requirements
- R1: While `rst_n` is low, `data_o`, `syn_o` and `err_o` are all zero, and this takes effect without waiting for a clock edge.
- R2: Residual j is `chk_i[j]` minus the sum of a group of data lanes. Group 0 is lanes 0,1,2. Group 1 is lanes 0,1,3. Group 2 is lanes 0,2,3. The arithmetic is signed at RW bits. Residual j drives `syn_o[2-j]`, so `syn_o[2]` comes from check 0 and `syn_o[0]` from check 2.
- R3: A syndrome bit is 0 when the residual's magnitude is strictly less than `thr_i` (unsigned). It is 1 when the magnitude is equal to or greater than `thr_i`.
- R4: Syndrome 3'b111 rebuilds lane 0 as chk0−d1−d2. 3'b110 rebuilds lane 1 as chk0−d0−d2. 3'b101 rebuilds lane 2 as chk0−d0−d1. 3'b011 rebuilds lane 3 as chk1−d0−d1.
- R5: With syndrome 3'b000 or any syndrome that has exactly one bit set, all four data lanes pass through unchanged.
- R6: `err_o` is 1 exactly when `syn_o` is non-zero. A one-bit syndrome (check-filter fault) also sets it.
- R7: All outputs are registered. Inputs applied before a rising edge appear at the outputs just after that edge, and not before it.
- R8: A rebuilt sample is the RW-bit signed result truncated to DW bits. It is correct for data samples at the extremes of the DW-bit signed range.
- R9: When one lane is rebuilt, the other three lanes still pass their input samples through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 4×DW | Data filter samples, lane i in `data_i[i]`, signed |
| chk_i | input | 3×CW | Check filter samples, check j in `chk_i[j]`, signed |
| thr_i | input | RW | Unsigned residual tolerance |
| data_o | output | 4×DW | Corrected data samples, signed |
| syn_o | output | 3 | Syndrome, `syn_o[2-j]` from check j |
| err_o | output | 1 | Non-zero syndrome flag |

## Verification
The properties assume that the check samples and data sums fit the RW-bit residual without wrapping. Otherwise a residual can alias to a small magnitude. They also assume that at most one filter is wrong in any one sample. The stimulus builds every vector from a consistent set of clean samples, within the 18-bit data and 20-bit check ranges. It then disturbs only one data lane or one check sample per vector, and only by an amount chosen to land below, at or above the tolerance. The extreme-range vector keeps the rebuilt value within the DW-bit range, so the truncation in R8 loses no information.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

    localparam int NLANE = 4;
    localparam int NCHK  = 3;

    // Which data lanes feed check j (bit i set = lane i is in the group)
    function automatic logic [NLANE-1:0] grp_mask(input int j);
        logic [NLANE-1:0] m;
        case (j)
            0:       m = 4'b0111;
            1:       m = 4'b1011;
            default: m = 4'b1101;
        endcase
        return m;
    endfunction

    // Syndrome signature of lane i: syndrome bit (NCHK-1-j) is lane i's membership in group j
    function automatic logic [NCHK-1:0] lane_code(input int i);
        logic [NCHK-1:0] c;
        logic [NLANE-1:0] m;
        c = '0;
        for (int j = 0; j < NCHK; j++) begin
            m = grp_mask(j);
            c[NCHK-1-j] = m[i];
        end
        return c;
    endfunction

    // First check whose group contains lane i; used to rebuild that lane
    function automatic int rebuild_src(input int i);
        int src;
        logic [NLANE-1:0] m;
        src = NCHK - 1;
        for (int j = NCHK - 1; j >= 0; j--) begin
            m = grp_mask(j);
            if (m[i]) src = j;
        end
        return src;
    endfunction

endpackage

// File: rtl/fmc_residual.sv
module fmc_residual
    import fmc_pkg::*;
#(
    parameter int DW   = 18,
    parameter int CW   = 20,
    parameter int RW   = 20,
    parameter int CHK  = 0
) (
    input  logic [NLANE-1:0][DW-1:0] data_i,
    input  logic [CW-1:0]            chk_i,
    input  logic [RW-1:0]            thr_i,
    output logic                     bit_o
);
    localparam logic [NLANE-1:0] MASK = grp_mask(CHK);

    logic signed [RW-1:0] resid;
    logic        [RW-1:0] mag;

    always_comb begin
        resid = RW'($signed(chk_i));
        for (int i = 0; i < NLANE; i++) begin
            if (MASK[i]) resid = resid - RW'($signed(data_i[i]));
        end
        // the most negative value maps to 2^(RW-1), which still fits unsigned RW bits
        mag   = resid[RW-1] ? (~resid + 1'b1) : resid;
        bit_o = !(mag < thr_i);
    end

endmodule

// File: rtl/fmc_rebuild_lane.sv
module fmc_rebuild_lane
    import fmc_pkg::*;
#(
    parameter int DW = 18,
    parameter int CW = 20,
    parameter int RW = 20
) (
    input  logic [NLANE-1:0][DW-1:0] data_i,
    input  logic [NCHK-1:0][CW-1:0]  chk_i,
    input  logic [NCHK-1:0]          syn_i,
    output logic [NLANE-1:0][DW-1:0] data_o
);
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        localparam int               SRC  = rebuild_src(i);
        localparam logic [NLANE-1:0] MASK = grp_mask(SRC);
        localparam logic [NCHK-1:0]  CODE = lane_code(i);

        logic signed [RW-1:0] fixed;

        always_comb begin
            fixed = RW'($signed(chk_i[SRC]));
            for (int k = 0; k < NLANE; k++) begin
                if (MASK[k] && (k != i)) fixed = fixed - RW'($signed(data_i[k]));
            end
            data_o[i] = (syn_i == CODE) ? DW'(fixed) : data_i[i];
        end
    end

endmodule

// File: rtl/fmc_vote.sv
module fmc_vote #(
    parameter int W = 72
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] v_o
);
    always_comb v_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/fault_mask_corrector.sv
module fault_mask_corrector
    import fmc_pkg::*;
#(
    parameter int DW = 18,
    parameter int CW = 20,
    parameter int RW = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLANE-1:0][DW-1:0] data_i,
    input  logic [NCHK-1:0][CW-1:0]  chk_i,
    input  logic [RW-1:0]            thr_i,
    output logic [NLANE-1:0][DW-1:0] data_o,
    output logic [NCHK-1:0]          syn_o,
    output logic                     err_o
);
    localparam int NCOPY = 3;
    localparam int VW    = NLANE * DW;

    typedef struct packed {
        logic [NLANE-1:0][DW-1:0] data;
        logic [NCHK-1:0]          syn;
        logic                     err;
    } out_t;

    out_t st_d, st_q;

    logic [NCHK-1:0]                 syn_now;
    logic [NCOPY-1:0][VW-1:0]        copy_v;
    logic [VW-1:0]                   voted;

    // independent residual paths, one per check
    for (genvar j = 0; j < NCHK; j++) begin : g_res
        fmc_residual #(.DW(DW), .CW(CW), .RW(RW), .CHK(j)) u_res (
            .data_i (data_i),
            .chk_i  (chk_i[j]),
            .thr_i  (thr_i),
            .bit_o  (syn_now[NCHK-1-j])
        );
    end

    // triplicated rebuild-and-select stage
    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        logic [NLANE-1:0][DW-1:0] lane_v;
        fmc_rebuild_lane #(.DW(DW), .CW(CW), .RW(RW)) u_lane (
            .data_i (data_i),
            .chk_i  (chk_i),
            .syn_i  (syn_now),
            .data_o (lane_v)
        );
        assign copy_v[c] = lane_v;
    end

    fmc_vote #(.W(VW)) u_vote (
        .a_i (copy_v[0]),
        .b_i (copy_v[1]),
        .c_i (copy_v[2]),
        .v_o (voted)
    );

    always_comb begin
        st_d      = st_q;
        st_d.data = voted;
        st_d.syn  = syn_now;
        st_d.err  = |syn_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign syn_o  = st_q.syn;
    assign err_o  = st_q.err;

endmodule

// File: rtl/fmc_checker.sv
module fmc_checker
    import fmc_pkg::*;
#(
    parameter int DW = 18,
    parameter int CW = 20,
    parameter int RW = 20
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NLANE-1:0][DW-1:0] data_i,
    input logic [NCHK-1:0][CW-1:0]  chk_i,
    input logic [NLANE-1:0][DW-1:0] data_o,
    input logic [NCHK-1:0]          syn_o,
    input logic                     err_o
);
    logic primed_q;
    logic signed [RW-1:0] want0, want3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    always_comb begin
        want0 = RW'($signed(chk_i[0])) - RW'($signed(data_i[1])) - RW'($signed(data_i[2]));
        want3 = RW'($signed(chk_i[1])) - RW'($signed(data_i[0])) - RW'($signed(data_i[1]));
    end

    // R5: zero or one-bit syndrome leaves the data untouched
    a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $countones(syn_o) <= 1) |-> (data_o == $past(data_i)));

    // R6: flag follows the syndrome
    a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == (syn_o != '0));

    // R4: lane 0 rebuilt from check 0
    a_r4_rebuild_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && syn_o == 3'b111) |-> (data_o[0] == DW'($past(want0))));

    // R4: lane 3 rebuilt from check 1
    a_r4_rebuild_lane3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && syn_o == 3'b011) |-> (data_o[3] == DW'($past(want3))));

    // R9: lanes other than the rebuilt one pass through
    a_r9_others: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && syn_o == 3'b110) |->
        (data_o[0] == $past(data_i[0]) && data_o[2] == $past(data_i[2]) &&
         data_o[3] == $past(data_i[3])));

endmodule

bind fault_mask_corrector fmc_checker #(.DW(DW), .CW(CW), .RW(RW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_i (data_i),
    .chk_i  (chk_i),
    .data_o (data_o),
    .syn_o  (syn_o),
    .err_o  (err_o)
);

// File: tb/fault_mask_corrector_test.sv
`timescale 1ns/1ps
module fault_mask_corrector_test;
    localparam int DW = 18;
    localparam int CW = 20;
    localparam int RW = 20;
    localparam int NV = 11;

    typedef struct packed {
        int d0, d1, d2, d3;
        int c0, c1, c2;
        int thr;
        int e0, e1, e2, e3;
        logic [2:0] syn;
        logic       err;
    } vec_t;

    // clean set (10,20,30,40) gives checks (60,70,80)
    localparam vec_t VEC [NV] = '{
        '{10, 20, 30, 40, 60, 70, 80, 4, 10, 20, 30, 40, 3'b000, 1'b0},                 // clean
        '{110, 20, 30, 40, 60, 70, 80, 4, 10, 20, 30, 40, 3'b111, 1'b1},                // lane0 fault
        '{10, 70, 30, 40, 60, 70, 80, 4, 10, 20, 30, 40, 3'b110, 1'b1},                 // lane1 fault
        '{10, 20, 23, 40, 60, 70, 80, 4, 10, 20, 30, 40, 3'b101, 1'b1},                 // lane2 fault
        '{10, 20, 30, 49, 60, 70, 80, 4, 10, 20, 30, 40, 3'b011, 1'b1},                 // lane3 fault
        '{10, 20, 30, 40, 60, 170, 80, 4, 10, 20, 30, 40, 3'b010, 1'b1},                // check1 fault
        '{13, 20, 30, 40, 60, 70, 80, 4, 13, 20, 30, 40, 3'b000, 1'b0},                 // below thr
        '{14, 20, 30, 40, 60, 70, 80, 4, 10, 20, 30, 40, 3'b111, 1'b1},                 // at thr
        '{-100, -200, -500, -1000, -295, -1300, -1095, 4, -100, -200, 5, -1000, 3'b101, 1'b1},
        '{10, 520, 30, 40, 60, 70, 80, 1000, 10, 520, 30, 40, 3'b000, 1'b0},            // wide thr
        '{131071, -131072, 0, -131072, -1, 131070, 262142, 4, 131071, -131072, 0, 131071, 3'b011, 1'b1}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [3:0][DW-1:0]   data_i = '0;
    logic [2:0][CW-1:0]   chk_i = '0;
    logic [RW-1:0]        thr_i = '0;
    logic [3:0][DW-1:0]   data_o;
    logic [2:0]           syn_o;
    logic                 err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fault_mask_corrector #(.DW(DW), .CW(CW), .RW(RW)) uut (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .chk_i(chk_i),
        .thr_i(thr_i), .data_o(data_o), .syn_o(syn_o), .err_o(err_o)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int lane(input int i);
        return int'($signed(data_o[i]));
    endfunction

    task automatic apply(input vec_t v);
        data_i[0] = DW'(v.d0); data_i[1] = DW'(v.d1);
        data_i[2] = DW'(v.d2); data_i[3] = DW'(v.d3);
        chk_i[0]  = CW'(v.c0); chk_i[1]  = CW'(v.c1); chk_i[2] = CW'(v.c2);
        thr_i     = RW'(v.thr);
    endtask

    task automatic expect_vec(input vec_t v, input string req);
        check({req, " lane0"}, lane(0), v.e0);
        check({req, " lane1"}, lane(1), v.e1);
        check({req, " lane2"}, lane(2), v.e2);
        check({req, " lane3"}, lane(3), v.e3);
        check("R2/R3 syndrome", int'(syn_o), int'(v.syn));
        check("R6 err", int'(err_o), int'(v.err));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state with nonzero inputs present
        apply(VEC[1]);
        repeat (3) @(negedge clk);
        check("R1 data", int'(data_o), 0);
        check("R1 syn", int'(syn_o), 0);
        check("R1 err", int'(err_o), 0);
        rst_n = 1'b1;

        // table walk, one vector per cycle, checked one cycle later (R7)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            expect_vec(VEC[i], (i == 10) ? "R8" : ((i >= 1 && i <= 4) || i == 7 || i == 8) ? "R4" : "R5");
        end

        // R9: lane1 rebuilt, others unchanged, with distinct values
        apply('{5, 900, -7, 33, 5+(-300)+(-7), 5+(-300)+33, 5+(-7)+33, 2,
                5, -300, -7, 33, 3'b110, 1'b1});
        @(negedge clk);
        check("R9 lane0", lane(0), 5);
        check("R9 lane1 rebuilt", lane(1), -300);
        check("R9 lane2", lane(2), -7);
        check("R9 lane3", lane(3), 33);

        // R7: output holds until the next rising edge
        apply(VEC[3]);
        #5;
        check("R7 before edge", int'(syn_o), 3'b110);
        @(negedge clk);
        check("R7 after edge", int'(syn_o), 3'b101);

        // R5: two faulty checks seen as one-bit? use check2-only fault
        apply('{10, 20, 30, 40, 60, 70, 95, 4, 10, 20, 30, 40, 3'b001, 1'b1});
        @(negedge clk);
        check("R5 check2 fault lane0", lane(0), 10);
        check("R5 check2 fault syn", int'(syn_o), 3'b001);
        check("R6 check2 fault err", int'(err_o), 1);

        // R1: asynchronous reset mid-run clears outputs before any edge
        #2;
        rst_n = 1'b0;
        #1;
        check("R1 async data", int'(data_o), 0);
        check("R1 async err", int'(err_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 recovery syn", int'(syn_o), 3'b001);

        finish_run();
    end
endmodule